// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter of a small 16-bit load/store core and works out, every cycle, the address of the next instruction to fetch. The decoder tells it which source to take: the plain increment, a PC-relative branch target, an absolute in-page jump target, or a full 16-bit address read from a register. For the branch source the block evaluates the branch condition itself from the two operands it is given. The result is registered when the advance enable is high.

The block also provides the return address (current PC plus one) for the link register of the call instructions, and drives the word address of the 256-entry instruction store from the low bits of the PC. It does not hold the instruction store or the register file, and it does not detect hazards; a stall is expressed by dropping the advance enable.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low the PC is forced to 0, so after reset `pc_q` is 0x0000, `imem_addr` is 0x00 and `link_val` is 0x0001.
- R2: When `adv_en` is low, `pc_q` keeps its value at the clock edge whatever `nxt_sel` and the other inputs show.
- R3: With `nxt_sel` = 0 (increment) and `adv_en` high, `pc_q` becomes `pc_q`+1 modulo 2^16, so 0xFFFF wraps to 0x0000.
- R4: With `nxt_sel` = 1 (branch) and the condition true, `pc_q` becomes `pc_q`+1 plus the 5-bit `br_off` sign-extended to 16 bits (range -16..+15), modulo 2^16.
- R5: `br_kind` selects the condition: 0 `opnd_a`==`opnd_b`, 1 `opnd_a`!=`opnd_b`, 2 `opnd_a`>0, 3 `opnd_a`<0. `br_taken` is high only when `nxt_sel` = 1 and the condition holds; an untaken branch loads `pc_q`+1.
- R6: The tests against zero (kinds 2 and 3) treat `opnd_a` as signed two's complement: 0x8000 is below zero, 0x0000 is neither above nor below.
- R7: With `nxt_sel` = 2 (jump), `pc_q` becomes the current `pc_q[15:11]` followed by the 11-bit `jmp_tgt`.
- R8: With `nxt_sel` = 3 (register), `pc_q` becomes the 16-bit `reg_tgt`.
- R9: `link_val` always equals the current `pc_q`+1 modulo 2^16, the value a call writes into register 7.
- R10: `imem_addr` equals `pc_q[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_en | input | 1 | Advance enable; low holds the PC (stall) |
| nxt_sel | input | 2 | Next-PC source: 0 increment, 1 branch, 2 jump, 3 register |
| br_kind | input | 2 | Branch condition: 0 equal, 1 not equal, 2 above zero, 3 below zero |
| opnd_a | input | 16 | First branch operand |
| opnd_b | input | 16 | Second branch operand (equal / not equal only) |
| br_off | input | 5 | Signed branch offset |
| jmp_tgt | input | 11 | In-page jump target |
| reg_tgt | input | 16 | Register value for indirect jumps |
| pc_q | output | 16 | Current program counter |
| imem_addr | output | 8 | Instruction store word address |
| link_val | output | 16 | Return address for the link register |
| br_taken | output | 1 | Branch source selected and condition true |

## Verification
Wrap-around of the incrementer and a relative branch can meet in one cycle: a backward branch with offset -16 from a low PC must wrap below zero, and a jump taken from 0xFFF9 to 0xFFFF followed by an increment must wrap to zero. Both are placed in the stimulus table with the absolute PC expected after the edge, and the link value is compared at the same time because it shares the incrementer with the fall-through path. A stall that coincides with a jump select is also provoked and judged by the PC not moving.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

   typedef enum logic [1:0] {
      NX_STEP = 2'd0,
      NX_REL  = 2'd1,
      NX_PAGE = 2'd2,
      NX_IND  = 2'd3
   } nx_src_e;

   typedef enum logic [1:0] {
      BC_EQ  = 2'd0,
      BC_NE  = 2'd1,
      BC_POS = 2'd2,
      BC_NEG = 2'd3
   } br_cond_e;

endpackage

// File: rtl/pcnu_sext.sv
module pcnu_sext #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign dout = {{PAD_W{din[IN_W-1]}}, din};
      end else begin : g_same
         assign dout = din[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/pcnu_cond.sv
module pcnu_cond
   import pcnu_pkg::*;
#(
   parameter int DW          = 16,
   parameter bit SIGNED_ZERO = 1'b1
) (
   input  br_cond_e        kind,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic            hit
);
   logic eq_w;
   logic pos_w;
   logic neg_w;

   assign eq_w = (a == b);

   generate
      if (SIGNED_ZERO) begin : g_signed
         assign neg_w = a[DW-1];
         assign pos_w = ~a[DW-1] & (|a);
      end else begin : g_unsigned
         assign neg_w = 1'b0;
         assign pos_w = |a;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         BC_EQ:   hit = eq_w;
         BC_NE:   hit = ~eq_w;
         BC_POS:  hit = pos_w;
         BC_NEG:  hit = neg_w;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/pcnu_nextsel.sv
module pcnu_nextsel
   import pcnu_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int OFF_W = 5,
   parameter int JMP_W = 11
) (
   input  logic [PC_W-1:0]  pc_cur,
   input  nx_src_e          src,
   input  logic             cond_hit,
   input  logic [OFF_W-1:0] off,
   input  logic [JMP_W-1:0] page_tgt,
   input  logic [PC_W-1:0]  ind_tgt,
   output logic [PC_W-1:0]  seq_pc,
   output logic [PC_W-1:0]  pc_nxt
);
   localparam int HI_W = PC_W - JMP_W;

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] rel_pc;
   logic [PC_W-1:0] page_pc;

   pcnu_sext #(.IN_W(OFF_W), .OUT_W(PC_W)) u_sext (
      .din  (off),
      .dout (off_ext)
   );

   assign seq_pc  = pc_cur + {{(PC_W-1){1'b0}}, 1'b1};
   assign rel_pc  = seq_pc + off_ext;

   generate
      if (HI_W > 0) begin : g_page
         assign page_pc = {pc_cur[PC_W-1 -: HI_W], page_tgt};
      end else begin : g_flat
         assign page_pc = page_tgt[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (src)
         NX_STEP: pc_nxt = seq_pc;
         NX_REL:  pc_nxt = cond_hit ? rel_pc : seq_pc;
         NX_PAGE: pc_nxt = page_pc;
         NX_IND:  pc_nxt = ind_tgt;
         default: pc_nxt = seq_pc;
      endcase
   end
endmodule

// File: rtl/pcnu_pcreg.sv
module pcnu_pcreg #(
   parameter int              PC_W     = 16,
   parameter logic [PC_W-1:0] RST_ADDR = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [PC_W-1:0] d,
   output logic [PC_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RST_ADDR;
      end else if (en) begin
         q <= d;
      end
   end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pcnu_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int OFF_W       = 5,
   parameter int JMP_W       = 11,
   parameter int IMEM_AW     = 8,
   parameter bit SIGNED_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv_en,
   input  logic [1:0]         nxt_sel,
   input  logic [1:0]         br_kind,
   input  logic [PC_W-1:0]    opnd_a,
   input  logic [PC_W-1:0]    opnd_b,
   input  logic [OFF_W-1:0]   br_off,
   input  logic [JMP_W-1:0]   jmp_tgt,
   input  logic [PC_W-1:0]    reg_tgt,
   output logic [PC_W-1:0]    pc_q,
   output logic [IMEM_AW-1:0] imem_addr,
   output logic [PC_W-1:0]    link_val,
   output logic               br_taken
);
   generate
      if (JMP_W > PC_W) begin : g_bad_jmp
         $error("pc_next_unit: JMP_W exceeds PC_W");
      end
      if (OFF_W >= PC_W || OFF_W < 2) begin : g_bad_off
         $error("pc_next_unit: OFF_W out of range");
      end
      if (IMEM_AW > PC_W || IMEM_AW < 1) begin : g_bad_aw
         $error("pc_next_unit: IMEM_AW out of range");
      end
   endgenerate

   nx_src_e         src_w;
   br_cond_e        kind_w;
   logic            hit_w;
   logic [PC_W-1:0] seq_w;
   logic [PC_W-1:0] nxt_w;

   assign src_w  = nx_src_e'(nxt_sel);
   assign kind_w = br_cond_e'(br_kind);

   pcnu_cond #(.DW(PC_W), .SIGNED_ZERO(SIGNED_ZERO)) u_cond (
      .kind (kind_w),
      .a    (opnd_a),
      .b    (opnd_b),
      .hit  (hit_w)
   );

   pcnu_nextsel #(.PC_W(PC_W), .OFF_W(OFF_W), .JMP_W(JMP_W)) u_nsel (
      .pc_cur   (pc_q),
      .src      (src_w),
      .cond_hit (hit_w),
      .off      (br_off),
      .page_tgt (jmp_tgt),
      .ind_tgt  (reg_tgt),
      .seq_pc   (seq_w),
      .pc_nxt   (nxt_w)
   );

   pcnu_pcreg #(.PC_W(PC_W), .RST_ADDR('0)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv_en),
      .d     (nxt_w),
      .q     (pc_q)
   );

   assign imem_addr = pc_q[IMEM_AW-1:0];
   assign link_val  = seq_w;
   assign br_taken  = (src_w == NX_REL) & hit_w;
endmodule

// File: rtl/pcnu_chk.sv
module pcnu_chk #(
   parameter int PC_W  = 16,
   parameter int JMP_W = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            adv_en,
   input logic [1:0]      nxt_sel,
   input logic [PC_W-1:0] reg_tgt,
   input logic [PC_W-1:0] pc_q,
   input logic [PC_W-1:0] link_val,
   input logic            br_taken
);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> $stable(pc_q));

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && nxt_sel == 2'd0) |=> pc_q == $past(link_val));

   a_r5_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && nxt_sel == 2'd1 && !br_taken) |=> pc_q == $past(link_val));

   a_r5_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_sel != 2'd1) |-> !br_taken);

   a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && nxt_sel == 2'd2) |=>
         pc_q[PC_W-1:JMP_W] == $past(pc_q[PC_W-1:JMP_W]));

   a_r8_indirect: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && nxt_sel == 2'd3) |=> pc_q == $past(reg_tgt));
endmodule

bind pc_next_unit pcnu_chk #(.PC_W(PC_W), .JMP_W(JMP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .adv_en   (adv_en),
   .nxt_sel  (nxt_sel),
   .reg_tgt  (reg_tgt),
   .pc_q     (pc_q),
   .link_val (link_val),
   .br_taken (br_taken)
);

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb;
   localparam int NV = 16;

   // packing: sel kind a b off tgt reg exp taken = 85 bits
   function automatic logic [84:0] mk(input logic [1:0] s, input logic [1:0] k,
      input logic [15:0] a, input logic [15:0] b, input logic [4:0] o,
      input logic [10:0] t, input logic [15:0] r, input logic [15:0] e,
      input logic tk);
      return {s, k, a, b, o, t, r, e, tk};
   endfunction

   localparam logic [84:0] VEC [NV] = '{
      mk(2'd0, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h000, 16'h0000, 16'h0001, 1'b0), // R3
      mk(2'd0, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h000, 16'h0000, 16'h0002, 1'b0), // R3
      mk(2'd1, 2'd0, 16'h0005, 16'h0005, 5'd3,  11'h000, 16'h0000, 16'h0006, 1'b1), // R4 eq
      mk(2'd1, 2'd1, 16'h0005, 16'h0005, 5'd3,  11'h000, 16'h0000, 16'h0007, 1'b0), // R5 ne untaken
      mk(2'd1, 2'd1, 16'h0001, 16'h0002, 5'h10, 11'h000, 16'h0000, 16'hFFF8, 1'b1), // R4 -16 wraps
      mk(2'd0, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h000, 16'h0000, 16'hFFF9, 1'b0), // R3
      mk(2'd2, 2'd0, 16'h0005, 16'h0005, 5'd0,  11'h7FF, 16'h0000, 16'hFFFF, 1'b0), // R7
      mk(2'd0, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h000, 16'h0000, 16'h0000, 1'b0), // R3 wrap
      mk(2'd3, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h000, 16'h1234, 16'h1234, 1'b0), // R8
      mk(2'd1, 2'd2, 16'h8000, 16'h0000, 5'd15, 11'h000, 16'h0000, 16'h1235, 1'b0), // R6 gtz neg
      mk(2'd1, 2'd3, 16'h8000, 16'h0000, 5'd15, 11'h000, 16'h0000, 16'h1245, 1'b1), // R6 ltz +15
      mk(2'd1, 2'd2, 16'h0001, 16'h0000, 5'd2,  11'h000, 16'h0000, 16'h1248, 1'b1), // R6 gtz
      mk(2'd1, 2'd3, 16'h0000, 16'h0000, 5'd2,  11'h000, 16'h0000, 16'h1249, 1'b0), // R6 zero
      mk(2'd1, 2'd2, 16'h0000, 16'h0000, 5'd2,  11'h000, 16'h0000, 16'h124A, 1'b0), // R6 zero
      mk(2'd2, 2'd0, 16'h0000, 16'h0000, 5'd0,  11'h005, 16'h0000, 16'h1005, 1'b0), // R7
      mk(2'd1, 2'd0, 16'h0003, 16'h0004, 5'd1,  11'h000, 16'h0000, 16'h1006, 1'b0)  // R5 eq untaken
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv_en;
   logic [1:0]  nxt_sel;
   logic [1:0]  br_kind;
   logic [15:0] opnd_a;
   logic [15:0] opnd_b;
   logic [4:0]  br_off;
   logic [10:0] jmp_tgt;
   logic [15:0] reg_tgt;
   logic [15:0] pc_q;
   logic [7:0]  imem_addr;
   logic [15:0] link_val;
   logic        br_taken;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pc_next_unit u_dut (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .nxt_sel(nxt_sel),
      .br_kind(br_kind), .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off),
      .jmp_tgt(jmp_tgt), .reg_tgt(reg_tgt), .pc_q(pc_q), .imem_addr(imem_addr),
      .link_val(link_val), .br_taken(br_taken)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] cur;
      rst_n = 1'b0; adv_en = 1'b0; nxt_sel = 2'd0; br_kind = 2'd0;
      opnd_a = '0; opnd_b = '0; br_off = '0; jmp_tgt = '0; reg_tgt = '0;
      repeat (3) @(negedge clk);
      chk("R1 pc", pc_q, 16'h0000);
      chk("R10 imem", {8'h00, imem_addr}, 16'h0000);
      chk("R9 link", link_val, 16'h0001);
      rst_n = 1'b1;
      adv_en = 1'b1;
      cur = 16'h0000;

      for (int i = 0; i < NV; i++) begin
         logic [84:0] v;
         v = VEC[i];
         nxt_sel = v[84:83]; br_kind = v[82:81]; opnd_a = v[80:65];
         opnd_b = v[64:49];  br_off = v[48:44];  jmp_tgt = v[43:33];
         reg_tgt = v[32:17];
         #1;
         chk("R5 taken", {15'd0, br_taken}, {15'd0, v[0]});
         chk("R9 link", link_val, cur + 16'd1);
         @(posedge clk);
         @(negedge clk);
         chk("R3/R4/R7/R8 next pc", pc_q, v[16:1]);
         chk("R10 imem", {8'h00, imem_addr}, {8'h00, v[8:1]});
         cur = v[16:1];
      end

      // R2: stall while a jump is selected
      adv_en = 1'b0; nxt_sel = 2'd2; jmp_tgt = 11'h3AA;
      repeat (2) @(negedge clk);
      chk("R2 hold", pc_q, cur);
      nxt_sel = 2'd3; reg_tgt = 16'hBEEF;
      @(negedge clk);
      chk("R2 hold reg", pc_q, cur);

      // R5: equal operands with a non-branch select do not flag taken
      nxt_sel = 2'd0; br_kind = 2'd0; opnd_a = 16'h7; opnd_b = 16'h7;
      #1;
      chk("R5 no taken off-branch", {15'd0, br_taken}, 16'd0);

      // R9/R3: link value at the top of the address space
      adv_en = 1'b1; nxt_sel = 2'd3; reg_tgt = 16'hFFFF;
      @(negedge clk);
      chk("R8 reg load", pc_q, 16'hFFFF);
      chk("R9 link wrap", link_val, 16'h0000);
      chk("R10 imem top", {8'h00, imem_addr}, 16'h00FF);

      // R1: reset in mid-run
      nxt_sel = 2'd0; rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset", pc_q, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 after reset", pc_q, 16'h0001);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule